// File: doc/BRIEF.md
# Control-Flow Execution Monitor

This block is a trusted checker that sits beside a microcoded, bus-based processor and watches the processor's control-signal vector every cycle. It runs its own deterministic automaton that mirrors the microcode sequencer. In each state a per-state table gives the value each control field must hold and says which fields are don't-care. A valid vector that breaks the table ends the run in an absorbing fault state. Examples are an unexpected memory store during an add, or a missing register enable. A fetch-end dispatch whose opcode has no model ends the run the same way.

The tapped signals reach the monitor after a tap latency of one or two cycles. The monitor adds `MAX_TAP_LAT - TAP_LAT` retiming stages, so every build compares at the same point after the processor cycle. The predicate output stays high while every observed step is legal. The fault output rises once a step is illegal, and both hold until reset. The current automaton state is exported for debug.

The fetch sequence (four states), the no-op step and the three-step register-register add are modelled in full. Loads and multiplies reach one-cycle dispatch stubs that accept any vector and then return to the start of fetch.

Top module: `flow_monitor`

## Requirements
- R1: During and after reset, `mon_state` is 0 (start of fetch), `flow_ok` is 1 and `fault_flag` is 0.
- R2: A vector presented at the ports takes effect on `mon_state`, `flow_ok` and `fault_flag` at clock edge number `MAX_TAP_LAT - TAP_LAT + 1`, counting the presenting edge as 1, and not earlier.
- R3: The fetch states are encoded 0,1,2,3 and are walked in that order. State 0 needs load_ir=0, reg_sel=31 (PC), reg_wr=0, reg_en=1, load_a=1, alu_en=0, load_ma=1, mem_en=0 and imm_en=0. State 1 needs load_ir=1, reg_en=0, load_a=0, alu_en=0, load_ma=0, mem_wr=0, mem_en=1 and imm_en=0. State 2 needs load_ir=0, reg_sel=31, reg_wr=1, reg_en=1, load_a=0, alu_op=2 (increment by four), alu_en=1, mem_en=0 and imm_en=0. State 3 needs load_ir=0, reg_en=0, alu_en=0, mem_en=0 and imm_en=0.
- R4: A legal step in state 3 dispatches on `tap_opcode`: 0 goes to no-op (4), 1 goes to add (5), 2 goes to the load stub (8) and 3 goes to the multiply stub (9). Any other opcode goes to fault (15).
- R5: The add states 5,6,7 are fully strict. State 5 allows only reg_sel=0 (rs), reg_en=1 and load_a=1. State 6 allows only reg_sel=1 (rt), reg_en=1 and load_b=1. State 7 allows only reg_sel=2 (rd), reg_wr=1, alu_op=1 (ADD) and alu_en=1. Every other field must be 0, and state 7 returns to 0.
- R6: State 4 (no-op) needs every single-bit field at 0 and returns to 0. States 8 and 9 accept any vector and return to 0.
- R7: A valid vector that breaks the current state's requirement moves the monitor to fault (15), lowers `flow_ok` and raises `fault_flag`. One example is load_ma, mem_wr and mem_en raised in state 7.
- R8: Fault is absorbing. Once it is entered, `mon_state` stays 15, `flow_ok` stays 0 and `fault_flag` stays 1 whatever the inputs, until reset.
- R9: While `tap_valid` is 0 the vector is ignored: the state does not advance and no fault is raised.
- R10: Fields that are not listed for a state are don't-care, and any value in them leaves the outcome unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_valid | input | 1 | Observed vector is a real processor cycle |
| tap_ld_ir | input | 1 | Instruction register load strobe |
| tap_reg_sel | input | 5 | Register file select (0 rs, 1 rt, 2 rd, 30 link, 31 PC) |
| tap_reg_wr | input | 1 | Register file write |
| tap_reg_en | input | 1 | Register file drives the bus |
| tap_ld_a | input | 1 | A operand latch load |
| tap_ld_b | input | 1 | B operand latch load |
| tap_alu_op | input | 4 | ALU function (1 ADD, 2 increment by four) |
| tap_alu_en | input | 1 | ALU drives the bus |
| tap_ld_ma | input | 1 | Memory address latch load |
| tap_mem_wr | input | 1 | Memory write |
| tap_mem_en | input | 1 | Memory drives the bus |
| tap_ext_sel | input | 2 | Immediate extension select |
| tap_imm_en | input | 1 | Immediate drives the bus |
| tap_opcode | input | 6 | Opcode of the instruction register, used at dispatch |
| flow_ok | output | 1 | Predicate: high while the observed flow is legal |
| fault_flag | output | 1 | Sticky fault indication |
| mon_state | output | 4 | Current automaton state code |

## Verification
The bench builds two copies side by side with `MAX_TAP_LAT` = 2. One uses `TAP_LAT` = 1, which inserts one retiming stage. The other uses `TAP_LAT` = 2, which compares straight from the ports. Both copies see the same stimulus, so both alignment variants are exercised, and the one-cycle gap between their fault responses to the same illegal vector shows the alignment depth. Random legal flows with randomised don't-care fields, random single-field corruptions, random bad opcodes and idle cycles are mixed with directed cases: a hidden store during the add write-back, an illegal vector masked by a low valid, and recovery by reset.

// File: rtl/flowmon_pkg.sv
package flowmon_pkg;

  localparam int REG_SEL_W = 5;
  localparam int ALU_OP_W  = 4;
  localparam int EXT_SEL_W = 2;
  localparam int OPC_W     = 6;
  localparam int STATE_W   = 4;

  // register select codes
  localparam logic [REG_SEL_W-1:0] SEL_RS   = REG_SEL_W'(0);
  localparam logic [REG_SEL_W-1:0] SEL_RT   = REG_SEL_W'(1);
  localparam logic [REG_SEL_W-1:0] SEL_RD   = REG_SEL_W'(2);
  localparam logic [REG_SEL_W-1:0] SEL_LINK = REG_SEL_W'(30);
  localparam logic [REG_SEL_W-1:0] SEL_PC   = REG_SEL_W'(31);

  // ALU function codes
  localparam logic [ALU_OP_W-1:0] ALU_ADD  = ALU_OP_W'(1);
  localparam logic [ALU_OP_W-1:0] ALU_INC4 = ALU_OP_W'(2);

  // opcodes understood at dispatch
  localparam logic [OPC_W-1:0] OPC_NOP  = OPC_W'(0);
  localparam logic [OPC_W-1:0] OPC_ADD  = OPC_W'(1);
  localparam logic [OPC_W-1:0] OPC_LOAD = OPC_W'(2);
  localparam logic [OPC_W-1:0] OPC_MULT = OPC_W'(3);

  // observed control word, fields in sequencer column order
  typedef struct packed {
    logic                 ld_ir;
    logic [REG_SEL_W-1:0] reg_sel;
    logic                 reg_wr;
    logic                 reg_en;
    logic                 ld_a;
    logic                 ld_b;
    logic [ALU_OP_W-1:0]  alu_op;
    logic                 alu_en;
    logic                 ld_ma;
    logic                 mem_wr;
    logic                 mem_en;
    logic [EXT_SEL_W-1:0] ext_sel;
    logic                 imm_en;
  } ctl_vec_t;

  localparam int CV_W = $bits(ctl_vec_t);

  typedef enum logic [STATE_W-1:0] {
    S_FETCH_0 = 4'd0,
    S_FETCH_1 = 4'd1,
    S_FETCH_2 = 4'd2,
    S_FETCH_3 = 4'd3,
    S_NOP_0   = 4'd4,
    S_ADD_0   = 4'd5,
    S_ADD_1   = 4'd6,
    S_ADD_2   = 4'd7,
    S_LOAD_0  = 4'd8,
    S_MULT_0  = 4'd9,
    S_FAULT   = 4'd15
  } mon_state_e;

  // Value every cared field must carry in a state.
  function automatic ctl_vec_t spec_value(mon_state_e s);
    ctl_vec_t v;
    v = '0;
    case (s)
      S_FETCH_0: begin
        v.reg_sel = SEL_PC; v.reg_en = 1'b1; v.ld_a = 1'b1; v.ld_ma = 1'b1;
      end
      S_FETCH_1: begin
        v.ld_ir = 1'b1; v.mem_en = 1'b1;
      end
      S_FETCH_2: begin
        v.reg_sel = SEL_PC; v.reg_wr = 1'b1; v.reg_en = 1'b1;
        v.alu_op = ALU_INC4; v.alu_en = 1'b1;
      end
      S_ADD_0: begin
        v.reg_sel = SEL_RS; v.reg_en = 1'b1; v.ld_a = 1'b1;
      end
      S_ADD_1: begin
        v.reg_sel = SEL_RT; v.reg_en = 1'b1; v.ld_b = 1'b1;
      end
      S_ADD_2: begin
        v.reg_sel = SEL_RD; v.reg_wr = 1'b1; v.alu_op = ALU_ADD; v.alu_en = 1'b1;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  // Per-state mask: 1 = field is compared, 0 = don't-care.
  function automatic ctl_vec_t spec_care(mon_state_e s);
    ctl_vec_t c;
    c = '1;
    case (s)
      S_FETCH_0: begin
        c.ld_b = 1'b0; c.alu_op = '0; c.mem_wr = 1'b0; c.ext_sel = '0;
      end
      S_FETCH_1: begin
        c.reg_sel = '0; c.reg_wr = 1'b0; c.ld_b = 1'b0; c.alu_op = '0; c.ext_sel = '0;
      end
      S_FETCH_2: begin
        c.ld_b = 1'b0; c.ld_ma = 1'b0; c.mem_wr = 1'b0; c.ext_sel = '0;
      end
      S_FETCH_3: begin
        c.reg_sel = '0; c.reg_wr = 1'b0; c.ld_a = 1'b0; c.ld_b = 1'b0;
        c.alu_op = '0; c.ld_ma = 1'b0; c.mem_wr = 1'b0; c.ext_sel = '0;
      end
      S_NOP_0: begin
        c.reg_sel = '0; c.alu_op = '0; c.ext_sel = '0;
      end
      S_ADD_0, S_ADD_1, S_ADD_2: c = '1;
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic logic opcode_known(logic [OPC_W-1:0] opc);
    return (opc == OPC_NOP) || (opc == OPC_ADD) || (opc == OPC_LOAD) || (opc == OPC_MULT);
  endfunction

  function automatic mon_state_e dispatch_target(logic [OPC_W-1:0] opc);
    case (opc)
      OPC_NOP:  return S_NOP_0;
      OPC_ADD:  return S_ADD_0;
      OPC_LOAD: return S_LOAD_0;
      OPC_MULT: return S_MULT_0;
      default:  return S_FAULT;
    endcase
  endfunction

  // Successor of a state after a legal step.
  function automatic mon_state_e seq_successor(mon_state_e s, logic [OPC_W-1:0] opc);
    case (s)
      S_FETCH_0: return S_FETCH_1;
      S_FETCH_1: return S_FETCH_2;
      S_FETCH_2: return S_FETCH_3;
      S_FETCH_3: return dispatch_target(opc);
      S_ADD_0:   return S_ADD_1;
      S_ADD_1:   return S_ADD_2;
      S_NOP_0, S_ADD_2, S_LOAD_0, S_MULT_0: return S_FETCH_0;
      default:   return S_FAULT;
    endcase
  endfunction

endpackage

// File: rtl/flowmon_align.sv
module flowmon_align #(
  parameter int DEPTH = 1,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  if (DEPTH == 0) begin : g_direct
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end else begin : g_pipe
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      logic         vq;
      logic [W-1:0] dq;
      logic         vin;
      logic [W-1:0] din;
      if (g == 0) begin : g_head
        assign vin = in_valid;
        assign din = in_data;
      end else begin : g_link
        assign vin = g_stage[g-1].vq;
        assign din = g_stage[g-1].dq;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vq <= 1'b0;
          dq <= '0;
        end else begin
          vq <= vin;
          dq <= din;
        end
      end
    end
    assign out_valid = g_stage[DEPTH-1].vq;
    assign out_data  = g_stage[DEPTH-1].dq;

    if (DEPTH == 1) begin : g_chk
      AST_ALIGN_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R2
    end
  end

endmodule

// File: rtl/flowmon_compare.sv
module flowmon_compare
  import flowmon_pkg::*;
(
  input  mon_state_e state,
  input  ctl_vec_t   observed,
  output ctl_vec_t   field_err,
  output logic       vec_match
);

  ctl_vec_t expect_v;
  ctl_vec_t care_v;

  assign expect_v  = spec_value(state);
  assign care_v    = spec_care(state);
  assign field_err = (observed ^ expect_v) & care_v;
  assign vec_match = (field_err == '0);

endmodule

// File: rtl/flowmon_fsm.sv
module flowmon_fsm
  import flowmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic             step_match,
  input  logic [OPC_W-1:0] step_opcode,
  output mon_state_e       state_q,
  output logic             pred_q,
  output logic             fault_q
);

  mon_state_e state_d;
  logic       evt_miss;
  logic       evt_fault_entry;
  logic       evt_accept;

  always_comb begin
    state_d = state_q;
    if (state_q != S_FAULT && step_valid) begin
      state_d = step_match ? seq_successor(state_q, step_opcode) : S_FAULT;
    end
  end

  assign evt_miss        = step_valid && !step_match && (state_q != S_FAULT);
  assign evt_fault_entry = (state_d == S_FAULT) && (state_q != S_FAULT);
  assign evt_accept      = (state_d == S_FETCH_0) && (state_q != S_FETCH_0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FETCH_0;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= 1'b1;
    end else if (evt_fault_entry) begin
      pred_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (evt_fault_entry) begin
      fault_q <= 1'b1;
    end
  end

  AST_FAULT_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_FAULT |=> state_q == S_FAULT); // R8
  AST_PRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_q |=> !pred_q); // R8
  AST_PRED_VS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_q != fault_q); // R8
  AST_MISS_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_miss |=> (fault_q && state_q == S_FAULT)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> $stable(state_q)); // R9
  AST_ADD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ADD_2 && step_valid && step_match) |=> state_q == S_FETCH_0); // R5
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH_3 && step_valid && step_match && !opcode_known(step_opcode))
      |=> state_q == S_FAULT); // R4
  AST_ACCEPT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |-> (state_q == S_NOP_0 || state_q == S_ADD_2 ||
                    state_q == S_LOAD_0 || state_q == S_MULT_0)); // R6

endmodule

// File: rtl/flow_monitor.sv
module flow_monitor
  import flowmon_pkg::*;
#(
  parameter int TAP_LAT     = 1,
  parameter int MAX_TAP_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tap_valid,
  input  logic                 tap_ld_ir,
  input  logic [REG_SEL_W-1:0] tap_reg_sel,
  input  logic                 tap_reg_wr,
  input  logic                 tap_reg_en,
  input  logic                 tap_ld_a,
  input  logic                 tap_ld_b,
  input  logic [ALU_OP_W-1:0]  tap_alu_op,
  input  logic                 tap_alu_en,
  input  logic                 tap_ld_ma,
  input  logic                 tap_mem_wr,
  input  logic                 tap_mem_en,
  input  logic [EXT_SEL_W-1:0] tap_ext_sel,
  input  logic                 tap_imm_en,
  input  logic [OPC_W-1:0]     tap_opcode,
  output logic                 flow_ok,
  output logic                 fault_flag,
  output logic [STATE_W-1:0]   mon_state
);

  localparam int PAD      = MAX_TAP_LAT - TAP_LAT;
  localparam int BUNDLE_W = CV_W + OPC_W;

  ctl_vec_t            obs_raw;
  ctl_vec_t            obs_al;
  logic [OPC_W-1:0]    opc_al;
  logic                valid_al;
  logic [BUNDLE_W-1:0] bundle_in;
  logic [BUNDLE_W-1:0] bundle_al;
  ctl_vec_t            field_err;
  logic                vec_match;
  mon_state_e          state_q;
  logic                pred_q;
  logic                fault_q;

  always_comb begin
    obs_raw.ld_ir   = tap_ld_ir;
    obs_raw.reg_sel = tap_reg_sel;
    obs_raw.reg_wr  = tap_reg_wr;
    obs_raw.reg_en  = tap_reg_en;
    obs_raw.ld_a    = tap_ld_a;
    obs_raw.ld_b    = tap_ld_b;
    obs_raw.alu_op  = tap_alu_op;
    obs_raw.alu_en  = tap_alu_en;
    obs_raw.ld_ma   = tap_ld_ma;
    obs_raw.mem_wr  = tap_mem_wr;
    obs_raw.mem_en  = tap_mem_en;
    obs_raw.ext_sel = tap_ext_sel;
    obs_raw.imm_en  = tap_imm_en;
  end

  assign bundle_in = {tap_opcode, obs_raw};

  flowmon_align #(.DEPTH(PAD), .W(BUNDLE_W)) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tap_valid),
    .in_data   (bundle_in),
    .out_valid (valid_al),
    .out_data  (bundle_al)
  );

  assign obs_al = bundle_al[CV_W-1:0];
  assign opc_al = bundle_al[BUNDLE_W-1:CV_W];

  flowmon_compare u_compare (
    .state     (state_q),
    .observed  (obs_al),
    .field_err (field_err),
    .vec_match (vec_match)
  );

  flowmon_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_valid  (valid_al),
    .step_match  (vec_match),
    .step_opcode (opc_al),
    .state_q     (state_q),
    .pred_q      (pred_q),
    .fault_q     (fault_q)
  );

  assign flow_ok    = pred_q;
  assign fault_flag = fault_q;
  assign mon_state  = state_q;

  AST_STORE_IN_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_al && state_q == S_ADD_2 && obs_al.mem_wr) |=> fault_flag); // R7
  AST_ERR_NOT_CARED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_al && state_q == S_FETCH_3 && field_err == '0 && opcode_known(opc_al))
      |=> flow_ok); // R10

endmodule

// File: tb/test_flow_monitor.sv
module test_flow_monitor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       v_valid, v_ld_ir, v_wr, v_ren, v_lda, v_ldb, v_alen, v_ldma, v_memwr, v_memen, v_imm;
  logic [4:0] v_sel;
  logic [3:0] v_op;
  logic [1:0] v_ext;
  logic [5:0] v_opc;

  logic       ok_a, flt_a, ok_b, flt_b;
  logic [3:0] st_a, st_b;

  int checks = 0;
  int failures = 0;
  int exp_now = 0;
  int exp_d1 = 0;
  bit done = 0;

  // TAP_LAT=1: one retiming stage
  flow_monitor #(.TAP_LAT(1), .MAX_TAP_LAT(2)) i_flow_monitor (
    .clk(clk), .rst_n(rst_n), .tap_valid(v_valid), .tap_ld_ir(v_ld_ir),
    .tap_reg_sel(v_sel), .tap_reg_wr(v_wr), .tap_reg_en(v_ren), .tap_ld_a(v_lda),
    .tap_ld_b(v_ldb), .tap_alu_op(v_op), .tap_alu_en(v_alen), .tap_ld_ma(v_ldma),
    .tap_mem_wr(v_memwr), .tap_mem_en(v_memen), .tap_ext_sel(v_ext), .tap_imm_en(v_imm),
    .tap_opcode(v_opc), .flow_ok(ok_a), .fault_flag(flt_a), .mon_state(st_a));

  // TAP_LAT=2: compared straight from the ports
  flow_monitor #(.TAP_LAT(2), .MAX_TAP_LAT(2)) i_flow_monitor_lat2 (
    .clk(clk), .rst_n(rst_n), .tap_valid(v_valid), .tap_ld_ir(v_ld_ir),
    .tap_reg_sel(v_sel), .tap_reg_wr(v_wr), .tap_reg_en(v_ren), .tap_ld_a(v_lda),
    .tap_ld_b(v_ldb), .tap_alu_op(v_op), .tap_alu_en(v_alen), .tap_ld_ma(v_ldma),
    .tap_mem_wr(v_memwr), .tap_mem_en(v_memen), .tap_ext_sel(v_ext), .tap_imm_en(v_imm),
    .tap_opcode(v_opc), .flow_ok(ok_b), .fault_flag(flt_b), .mon_state(st_b));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // legality of the present stimulus for a state, restated from the requirements
  function automatic bit tb_legal(int st);
    case (st)
      0: return !v_ld_ir && v_sel == 31 && !v_wr && v_ren && v_lda && !v_alen && v_ldma && !v_memen && !v_imm;
      1: return v_ld_ir && !v_ren && !v_lda && !v_alen && !v_ldma && !v_memwr && v_memen && !v_imm;
      2: return !v_ld_ir && v_sel == 31 && v_wr && v_ren && !v_lda && v_op == 2 && v_alen && !v_memen && !v_imm;
      3: return !v_ld_ir && !v_ren && !v_alen && !v_memen && !v_imm;
      4: return !(v_ld_ir | v_wr | v_ren | v_lda | v_ldb | v_alen | v_ldma | v_memwr | v_memen | v_imm);
      5: return v_sel == 0 && v_ren && v_lda && !v_ldb && !v_wr && v_op == 0 && v_ext == 0 &&
                !(v_ld_ir | v_alen | v_ldma | v_memwr | v_memen | v_imm);
      6: return v_sel == 1 && v_ren && v_ldb && !v_lda && !v_wr && v_op == 0 && v_ext == 0 &&
                !(v_ld_ir | v_alen | v_ldma | v_memwr | v_memen | v_imm);
      7: return v_sel == 2 && v_wr && v_op == 1 && v_alen && !v_ren && !v_lda && !v_ldb && v_ext == 0 &&
                !(v_ld_ir | v_ldma | v_memwr | v_memen | v_imm);
      8, 9: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int tb_next(int st);
    if (st == 15 || !tb_legal(st)) return 15;
    case (st)
      0: return 1;
      1: return 2;
      2: return 3;
      3: case (int'(v_opc))
           0: return 4;
           1: return 5;
           2: return 8;
           3: return 9;
           default: return 15;
         endcase
      5: return 6;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int st);
    if (st <= 3) return "R3";
    if (st >= 5 && st <= 7) return "R5";
    if (st == 15) return "R8";
    return "R6";
  endfunction

  task automatic randomize_all();
    v_ld_ir = 1'($urandom); v_sel = 5'($urandom); v_wr = 1'($urandom); v_ren = 1'($urandom);
    v_lda = 1'($urandom); v_ldb = 1'($urandom); v_op = 4'($urandom); v_alen = 1'($urandom);
    v_ldma = 1'($urandom); v_memwr = 1'($urandom); v_memen = 1'($urandom);
    v_ext = 2'($urandom); v_imm = 1'($urandom); v_opc = 6'($urandom);
  endtask

  // legal vector for a state; don't-care fields stay random (R10)
  task automatic make_legal(int st, int opc);
    randomize_all();
    v_valid = 1'b1;
    case (st)
      0: begin v_ld_ir = 0; v_sel = 31; v_wr = 0; v_ren = 1; v_lda = 1; v_alen = 0; v_ldma = 1; v_memen = 0; v_imm = 0; end
      1: begin v_ld_ir = 1; v_ren = 0; v_lda = 0; v_alen = 0; v_ldma = 0; v_memwr = 0; v_memen = 1; v_imm = 0; end
      2: begin v_ld_ir = 0; v_sel = 31; v_wr = 1; v_ren = 1; v_lda = 0; v_op = 2; v_alen = 1; v_memen = 0; v_imm = 0; end
      3: begin v_ld_ir = 0; v_ren = 0; v_alen = 0; v_memen = 0; v_imm = 0; v_opc = 6'(opc); end
      4: begin v_ld_ir = 0; v_wr = 0; v_ren = 0; v_lda = 0; v_ldb = 0; v_alen = 0; v_ldma = 0; v_memwr = 0; v_memen = 0; v_imm = 0; end
      5, 6, 7: begin
        v_ld_ir = 0; v_wr = 0; v_ren = 0; v_lda = 0; v_ldb = 0; v_op = 0; v_alen = 0;
        v_ldma = 0; v_memwr = 0; v_memen = 0; v_ext = 0; v_imm = 0;
        if (st == 5) begin v_sel = 0; v_ren = 1; v_lda = 1; end
        if (st == 6) begin v_sel = 1; v_ren = 1; v_ldb = 1; end
        if (st == 7) begin v_sel = 2; v_wr = 1; v_op = 1; v_alen = 1; end
      end
      default: ;
    endcase
  endtask

  task automatic corrupt(int k);
    case (k)
      0: v_ld_ir = ~v_ld_ir;   1: v_sel = v_sel + 1;    2: v_wr = ~v_wr;
      3: v_ren = ~v_ren;       4: v_lda = ~v_lda;       5: v_ldb = ~v_ldb;
      6: v_op = v_op + 1;      7: v_alen = ~v_alen;     8: v_ldma = ~v_ldma;
      9: v_memwr = ~v_memwr;   10: v_memen = ~v_memen;  11: v_ext = v_ext + 1;
      default: v_imm = ~v_imm;
    endcase
  endtask

  // one clock: inputs already driven; sample 2 ns after the edge
  task automatic step();
    int nxt;
    @(posedge clk);
    #2;
    nxt = v_valid ? tb_next(exp_now) : exp_now;
    exp_d1 = exp_now;
    exp_now = nxt;
    chk(tag_of(exp_d1), "lat1 state", int'(st_a), exp_d1);
    chk("R2", "lat2 state", int'(st_b), exp_now);
    chk(exp_d1 == 15 ? "R7" : "R8", "lat1 flow_ok", int'(ok_a), exp_d1 != 15);
    chk(exp_d1 == 15 ? "R7" : "R8", "lat1 fault", int'(flt_a), exp_d1 == 15);
    chk(exp_now == 15 ? "R7" : "R8", "lat2 fault", int'(flt_b), exp_now == 15);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    v_valid = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk("R1", "reset state", int'(st_a), 0);
    chk("R1", "reset flow_ok", int'(ok_b), 1);
    chk("R1", "reset fault", int'(flt_a), 0);
    rst_n = 1'b1;
    exp_now = 0;
    exp_d1 = 0;
  endtask

  // drive one legal instruction through both copies
  task automatic run_instr(int opc);
    int guard = 0;
    do begin
      make_legal(exp_now, opc);
      step();
      guard++;
    end while (exp_now != 0 && exp_now != 15 && guard < 8);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    v_valid = 1'b0;
    randomize_all();
    do_reset();

    // R3 R4 R5 R6 R10: clean instructions with random don't-cares
    for (int i = 0; i < 24; i++) run_instr(i % 4);
    chk("R10", "flow_ok after clean run", int'(ok_a), 1);
    chk("R6", "back at fetch start", int'(st_b), 0);

    // R9: illegal vector in add state with valid low
    run_instr(1);
    make_legal(0, 0); step(); make_legal(1, 0); step(); make_legal(2, 0); step();
    make_legal(3, 1); step(); make_legal(5, 0); step();
    make_legal(6, 0); v_memwr = 1; v_valid = 0; step(); step();
    chk("R9", "ignored vector keeps add state", int'(st_b), 6);
    chk("R9", "ignored vector no fault", int'(flt_a), 0);
    make_legal(6, 0); step(); make_legal(7, 0); step();

    // R7 R2: hidden store in the add write-back
    make_legal(0, 0); step(); make_legal(1, 0); step(); make_legal(2, 0); step();
    make_legal(3, 1); step(); make_legal(5, 0); step(); make_legal(6, 0); step();
    make_legal(7, 0); v_ldma = 1; v_memwr = 1; v_memen = 1; step();
    chk("R2", "lat1 not yet faulted", int'(flt_a), 0);
    chk("R7", "lat2 faulted at once", int'(flt_b), 1);
    make_legal(0, 0); step();
    chk("R2", "lat1 faulted one edge later", int'(flt_a), 1);
    // R8: legal traffic cannot leave fault
    for (int i = 0; i < 6; i++) begin make_legal(i % 4, 0); step(); end
    chk("R8", "fault absorbing", int'(st_a), 15);
    chk("R8", "predicate held low", int'(ok_b), 0);
    do_reset();
    make_legal(0, 0); step();
    chk("R1", "monitor resumes after reset", int'(flt_b), 0);
    run_instr(0);

    // R4: unmodelled opcode
    make_legal(0, 0); step(); make_legal(1, 0); step(); make_legal(2, 0); step();
    make_legal(3, 37); step(); step();
    chk("R4", "bad opcode faults", int'(st_a), 15);
    do_reset();

    // random mix: corruption, idle cycles, bad opcodes
    begin
      int fwait = 0;
      for (int i = 0; i < 4000; i++) begin
        if (exp_now == 15 && exp_d1 == 15) begin
          fwait++;
          if (fwait > 3) begin do_reset(); fwait = 0; end
        end
        begin
          int opc = ($urandom % 20 == 0) ? 4 + int'($urandom % 60) : int'($urandom % 4);
          make_legal(exp_now, opc);
          if (exp_now == 15) randomize_all();
          if ($urandom % 40 == 0) corrupt(int'($urandom % 13));
          if ($urandom % 10 == 0) begin randomize_all(); v_valid = 1'b0; end
          step();
        end
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule